// File: doc/BRIEF.md
# Sequential Nonrestoring Unsigned Divider

This block divides an unsigned dividend by an unsigned divisor of the same width over several clock cycles and returns a quotient and a remainder. It keeps three working registers: a signed partial remainder one bit wider than the operands, a shift register that starts out holding the dividend and ends up holding the quotient, and a register for the divisor. Each cycle retires one quotient bit. The partial remainder and the quotient register shift left together, and the divisor is then added to or subtracted from the partial remainder. The sign the partial remainder had before the shift decides whether to add or subtract, so a failed subtraction is never undone in place. If the partial remainder is still negative after the last bit, one extra cycle adds the divisor back so that the remainder is correct.

To use it, the caller raises `start` for one cycle while `busy` is low, with both operands on the inputs. `done` pulses once the results are ready. The results stay on the outputs until the next accepted start. A zero divisor raises a divide-by-zero flag and completes at once with fixed result values.

Top module: `seq_nrdiv`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `div_zero`, `quotient` and `remainder` are all 0.
- R2: A `start` seen while `busy` is low with a nonzero divisor makes `busy` high from the next cycle. `busy` stays high until the cycle in which `done` pulses. `busy` never rises without such a start.
- R3: When `done` pulses and `div_zero` is 0, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor, using the operands captured at the accepted start.
- R4: With n = WIDTH and a nonzero divisor, `done` is seen n clock edges after the edge that accepted the start when the quotient is odd (bit 0 is 1). It is seen n+1 edges after that edge when the quotient is even, because of the one remainder-correction cycle.
- R5: `done` is high for exactly one cycle per operation and is never high together with `busy`.
- R6: A start with a divisor of 0 never raises `busy`. On the next cycle it gives `done` = 1, `div_zero` = 1, `quotient` all ones and `remainder` equal to the dividend.
- R7: A `start` while `busy` is high is ignored: the running division finishes with the operands captured at the accepted start and its usual latency.
- R8: A dividend smaller than the divisor gives quotient 0 and remainder equal to the dividend.
- R9: While idle, `quotient`, `remainder` and `div_zero` hold their values until the next accepted start. An accepted start with a nonzero divisor clears `div_zero`.
- R10: Dividing 8 by 3 gives quotient 2 and remainder 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; accepted only while not busy |
| dividend | input | WIDTH | Unsigned dividend, sampled on the accepting edge |
| divisor | input | WIDTH | Unsigned divisor, sampled on the accepting edge |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| quotient | output | WIDTH | Quotient, held until the next accepted start |
| remainder | output | WIDTH | Remainder, held until the next accepted start |
| div_zero | output | 1 | Set when the accepted divisor was zero |

## Verification
The checker reads the operands only on the edge where `start` is seen with `busy` low. It takes for granted that any later change on `dividend` and `divisor` does not matter, so it compares each result against that captured pair. The stimulus deliberately changes both operand inputs and pulses `start` during a running division, so the captured pair is the only valid reference. The latency property assumes an operation is always launched from the idle state, and the bench waits for `busy` to drop before it drives each start. Operand pairs include directed corner values (zero divisor, zero dividend, dividend below divisor, all-ones operands, the 8 by 3 case) plus a pseudo-random sweep with nonzero divisors, which gives both odd and even quotients.

// File: rtl/seq_nrdiv_pkg.sv
package seq_nrdiv_pkg;

   // Controller phases: idle, one quotient bit per cycle, final remainder fix-up.
   typedef enum logic [1:0] {
      NRD_IDLE = 2'd0,
      NRD_STEP = 2'd1,
      NRD_FIX  = 2'd2
   } nrd_phase_e;

   // Adder construction variants selectable at elaboration.
   localparam int NRD_ADDER_BEHAVIOURAL = 0;
   localparam int NRD_ADDER_XOR_CARRY   = 1;

endpackage

// File: rtl/seq_nrdiv_addsub.sv
module seq_nrdiv_addsub #(
   parameter int W     = 9,
   parameter int STYLE = 0
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic         do_sub,
   output logic [W-1:0] result
);
   import seq_nrdiv_pkg::*;

   generate
      if (STYLE == NRD_ADDER_BEHAVIOURAL) begin : g_behav
         always_comb begin
            if (do_sub) result = op_a - op_b;
            else        result = op_a + op_b;
         end
      end else begin : g_xor_carry
         // Single adder: invert the second operand and inject a carry for subtraction.
         logic [W-1:0] b_cond;
         logic [W-1:0] cin_vec;
         always_comb begin
            b_cond  = op_b ^ {W{do_sub}};
            cin_vec = {{(W-1){1'b0}}, do_sub};
            result  = op_a + b_cond + cin_vec;
         end
      end
   endgenerate

endmodule

// File: rtl/seq_nrdiv_ctrl.sv
module seq_nrdiv_ctrl #(
   parameter int WIDTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic divisor_zero,
   input  logic step_sign,
   output logic load,
   output logic load_zero,
   output logic step_en,
   output logic fix_en,
   output logic busy,
   output logic done
);
   import seq_nrdiv_pkg::*;

   localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

   nrd_phase_e      phase_q;
   logic [CW-1:0]   step_cnt_q;
   logic            done_q;

   always_comb begin
      load      = start && (phase_q == NRD_IDLE);
      load_zero = load && divisor_zero;
      step_en   = (phase_q == NRD_STEP);
      fix_en    = (phase_q == NRD_FIX);
      busy      = (phase_q != NRD_IDLE);
      done      = done_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= NRD_IDLE;
         step_cnt_q <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (phase_q)
            NRD_IDLE: begin
               if (start) begin
                  if (divisor_zero) begin
                     done_q <= 1'b1;
                  end else begin
                     phase_q    <= NRD_STEP;
                     step_cnt_q <= '0;
                  end
               end
            end
            NRD_STEP: begin
               step_cnt_q <= step_cnt_q + 1'b1;
               if (step_cnt_q == LAST_STEP) begin
                  if (step_sign) begin
                     phase_q <= NRD_FIX;
                  end else begin
                     phase_q <= NRD_IDLE;
                     done_q  <= 1'b1;
                  end
               end
            end
            NRD_FIX: begin
               phase_q <= NRD_IDLE;
               done_q  <= 1'b1;
            end
            default: phase_q <= NRD_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/seq_nrdiv_datapath.sv
module seq_nrdiv_datapath #(
   parameter int WIDTH       = 8,
   parameter int ADDER_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             load_zero,
   input  logic             step_en,
   input  logic             fix_en,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic             step_sign,
   output logic [WIDTH-1:0] quotient,
   output logic [WIDTH-1:0] remainder,
   output logic             div_zero
);
   localparam int AW = WIDTH + 1;

   logic [AW-1:0]    part_q;     // signed partial remainder
   logic [WIDTH-1:0] qreg_q;     // dividend in, quotient out
   logic [WIDTH-1:0] dvs_q;
   logic             dz_q;

   logic [AW-1:0]    shifted;
   logic [AW-1:0]    add_a;
   logic [AW-1:0]    add_b;
   logic             add_sub;
   logic [AW-1:0]    sum;

   always_comb begin
      shifted = {part_q[WIDTH-1:0], qreg_q[WIDTH-1]};
      add_a   = fix_en ? part_q : shifted;
      // A non-negative partial remainder subtracts; a negative one adds back.
      add_sub = fix_en ? 1'b0 : ~part_q[WIDTH];
      add_b   = {1'b0, dvs_q};
   end

   seq_nrdiv_addsub #(
      .W     (AW),
      .STYLE (ADDER_STYLE)
   ) u_addsub (
      .op_a   (add_a),
      .op_b   (add_b),
      .do_sub (add_sub),
      .result (sum)
   );

   assign step_sign = sum[WIDTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_q <= '0;
         qreg_q <= '0;
         dvs_q  <= '0;
         dz_q   <= 1'b0;
      end else if (load) begin
         dvs_q <= divisor;
         if (load_zero) begin
            part_q <= {1'b0, dividend};
            qreg_q <= '1;
            dz_q   <= 1'b1;
         end else begin
            part_q <= '0;
            qreg_q <= dividend;
            dz_q   <= 1'b0;
         end
      end else if (step_en) begin
         part_q <= sum;
         qreg_q <= {qreg_q[WIDTH-2:0], ~sum[WIDTH]};
      end else if (fix_en) begin
         part_q <= sum;
      end
   end

   assign quotient  = qreg_q;
   assign remainder = part_q[WIDTH-1:0];
   assign div_zero  = dz_q;

endmodule

// File: rtl/seq_nrdiv.sv
module seq_nrdiv #(
   parameter int WIDTH       = 8,
   parameter int ADDER_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] dividend,
   input  logic [WIDTH-1:0] divisor,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] quotient,
   output logic [WIDTH-1:0] remainder,
   output logic             div_zero
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("seq_nrdiv: WIDTH must be at least 2");
      end
      if (ADDER_STYLE < 0 || ADDER_STYLE > 1) begin : g_bad_style
         $error("seq_nrdiv: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   logic load, load_zero, step_en, fix_en, step_sign;
   logic divisor_zero;

   assign divisor_zero = (divisor == '0);

   seq_nrdiv_ctrl #(
      .WIDTH (WIDTH)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .divisor_zero (divisor_zero),
      .step_sign    (step_sign),
      .load         (load),
      .load_zero    (load_zero),
      .step_en      (step_en),
      .fix_en       (fix_en),
      .busy         (busy),
      .done         (done)
   );

   seq_nrdiv_datapath #(
      .WIDTH       (WIDTH),
      .ADDER_STYLE (ADDER_STYLE)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_zero (load_zero),
      .step_en   (step_en),
      .fix_en    (fix_en),
      .dividend  (dividend),
      .divisor   (divisor),
      .step_sign (step_sign),
      .quotient  (quotient),
      .remainder (remainder),
      .div_zero  (div_zero)
   );

endmodule

// File: rtl/seq_nrdiv_chk.sv
module seq_nrdiv_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [WIDTH-1:0] dividend,
   input logic [WIDTH-1:0] divisor,
   input logic             busy,
   input logic             done,
   input logic [WIDTH-1:0] quotient,
   input logic [WIDTH-1:0] remainder,
   input logic             div_zero
);
   localparam int DW = 2 * WIDTH;
   localparam int LW = $clog2(WIDTH + 2) + 1;

   logic [WIDTH-1:0] cap_dd, cap_dv;
   logic [LW-1:0]    lat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_dd  <= '0;
         cap_dv  <= '0;
         lat_cnt <= '0;
      end else if (start && !busy) begin
         cap_dd  <= dividend;
         cap_dv  <= divisor;
         lat_cnt <= '0;
      end else if (busy) begin
         lat_cnt <= lat_cnt + 1'b1;
      end
   end

   AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && divisor != '0) |=> busy); // R2

   AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)); // R2

   AST_RESULT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_zero) |-> ((DW'(quotient) * DW'(cap_dv) + DW'(remainder) == DW'(cap_dd))
                               && (remainder < cap_dv))); // R3

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_zero) |-> (quotient[0] ? (lat_cnt == LW'(WIDTH)) : (lat_cnt == LW'(WIDTH + 1)))); // R4

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !(start && divisor == '0)) |=> !done); // R5

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy)); // R5

   AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && divisor == '0) |=> (done && div_zero && !busy && quotient == '1
                                              && remainder == $past(dividend))); // R6

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero))); // R9

endmodule

bind seq_nrdiv seq_nrdiv_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .dividend  (dividend),
   .divisor   (divisor),
   .busy      (busy),
   .done      (done),
   .quotient  (quotient),
   .remainder (remainder),
   .div_zero  (div_zero)
);

// File: tb/seq_nrdiv_test.sv
`timescale 1ns/1ps
module seq_nrdiv_test;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] dividend = '0;
   logic [W-1:0] divisor = '0;
   logic         busy, done, div_zero;
   logic [W-1:0] quotient, remainder;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   seq_nrdiv #(.WIDTH(W), .ADDER_STYLE(0)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
      .busy(busy), .done(done), .quotient(quotient), .remainder(remainder), .div_zero(div_zero)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Behavioural reference, advanced on every rising edge.
   bit m_busy, m_done, m_dz;
   int m_cnt, m_lat, m_q, m_r, p_q, p_r;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_dz = 0;
         m_cnt = 0; m_lat = 0; m_q = 0; m_r = 0; p_q = 0; p_r = 0;
      end else begin
         m_done = 0;
         if (!m_busy && start) begin
            if (divisor == 0) begin
               m_dz = 1; m_q = (1 << W) - 1; m_r = int'(dividend); m_done = 1;
            end else begin
               m_dz = 0;
               p_q = int'(dividend) / int'(divisor);
               p_r = int'(dividend) % int'(divisor);
               m_lat = (p_q % 2 == 1) ? W : W + 1;
               m_cnt = 0; m_busy = 1;
            end
         end else if (m_busy) begin
            m_cnt++;
            if (m_cnt == m_lat) begin
               m_busy = 0; m_done = 1; m_q = p_q; m_r = p_r;
            end
         end
      end
   end

   // Compare every cycle, away from the active edge.
   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy == m_busy, "R2", "busy", busy, m_busy);
         chk(done == m_done, "R5", "done", done, m_done);
         chk(div_zero == m_dz, "R6", "div_zero", div_zero, m_dz);
         if (!m_busy) begin
            chk(quotient == m_q, "R9", "held quotient", quotient, m_q);
            chk(remainder == m_r, "R9", "held remainder", remainder, m_r);
         end
      end
   end

   task automatic run_div(input int dd, input int dv, input string req, input bit poke);
      int k;
      int exp_q, exp_r, exp_l;
      exp_q = (dv == 0) ? (1 << W) - 1 : dd / dv;
      exp_r = (dv == 0) ? dd : dd % dv;
      exp_l = (dv == 0) ? 0 : ((exp_q % 2 == 1) ? W : W + 1);
      while (busy) @(negedge clk);
      dividend = W'(dd); divisor = W'(dv); start = 1'b1;
      @(negedge clk);
      start = 1'b0; k = 1;
      if (poke) begin
         // R7: a second request mid-run with different operands must be ignored.
         dividend = W'(~dd); divisor = W'(dv + 1); start = 1'b1;
         @(negedge clk);
         start = 1'b0; k++;
      end
      while (!done && k < 40) begin
         @(negedge clk);
         k++;
      end
      chk(done == 1'b1, req, "done seen", done, 1);
      chk(k - 1 == exp_l, "R4", "latency", k - 1, exp_l);
      chk(quotient == W'(exp_q), req, "quotient", quotient, exp_q);
      chk(remainder == W'(exp_r), req, "remainder", remainder, exp_r);
      chk(div_zero == (dv == 0), "R6", "div_zero at done", div_zero, dv == 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(busy == 0, "R1", "busy in reset", busy, 0);
      chk(done == 0, "R1", "done in reset", done, 0);
      chk(div_zero == 0, "R1", "div_zero in reset", div_zero, 0);
      chk(quotient == 0, "R1", "quotient in reset", quotient, 0);
      chk(remainder == 0, "R1", "remainder in reset", remainder, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && done == 0, "R1", "idle after reset", {busy, done}, 0);

      run_div(8, 3, "R10", 0);
      run_div(9, 3, "R3", 0);
      run_div(7, 3, "R3", 0);
      run_div(255, 1, "R3", 0);
      run_div(255, 255, "R3", 0);
      run_div(1, 255, "R8", 0);
      run_div(0, 5, "R8", 0);
      run_div(3, 200, "R8", 0);
      run_div(200, 0, "R6", 0);
      // R9: outputs hold while idle, even with operand inputs moving
      for (int i = 0; i < 5; i++) begin
         dividend = W'(i * 37); divisor = W'(i * 11);
         @(negedge clk);
      end
      chk(quotient == 255 && remainder == 200, "R9", "hold after zero divide",
          {quotient, remainder}, {8'd255, 8'd200});
      run_div(100, 7, "R7", 1);
      chk(div_zero == 0, "R9", "div_zero cleared", div_zero, 0);
      run_div(0, 0, "R6", 0);
      run_div(77, 77, "R3", 1);

      lfsr = 16'hACE1;
      for (int n = 0; n < 40; n++) begin
         int a, b;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         a = int'(lfsr[7:0]);
         b = int'(lfsr[15:8]) >> (n % 8);
         if (b == 0) b = 1 + (n % 13);
         run_div(a, b, "R3", 0);
      end

      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule